// File: doc/BRIEF.md
# Interrupt Request Capture Stage

This block holds the pending state for a bank of interrupt request lines. Every line is set up as edge-sensitive or level-sensitive. An edge line catches a fresh assertion of its input and keeps it after the input drops. A level line tracks its input, and it cannot be cleared by software while that input is still high. The raw inputs are asynchronous. They pass through a synchronizer, and a registered copy of the synchronized levels is kept so that changes can be detected.

Software acts on the pending state through three plain request strobes. A mask-write clears pending bits. A set-write raises one request. An acknowledge names a single line number. The block drives the pending vector and a one-cycle strobe that marks newly pending lines. Masking, arbitration and bus decoding are left to neighbouring logic. No port has a valid/ready handshake. A request is accepted in the cycle its strobe is high, and the block never applies back-pressure, so the requester needs no flow control.

Top module: `irq_capture_latch`

## Requirements
- R1: Each line has a sense bit. Value 0 selects edge mode and value 1 selects level mode. A cycle with `sense_we` high loads `sense_wdata` into all sense bits, and the new modes govern the following cycle.
- R2: An edge line becomes pending only when its synchronized input changes from 0 to 1. An input that stays high after the line was cleared does not set the line again.
- R3: A level line becomes pending in every cycle in which its synchronized input is high.
- R4: When the synchronized input falls, a level line clears its pending bit. An edge line keeps its pending bit.
- R5: A clear-write replaces pending with pending AND `clr_wdata`. A level line whose synchronized input is high stays pending.
- R6: An acknowledge (`ack_valid` with line number `ack_line`) clears that line's pending bit if the line is in edge mode. A level line is not affected.
- R7: A set-write makes only the lowest set bit of `set_wdata` pending. A write of zero changes nothing.
- R8: After reset, pending, `new_pend`, the synchronizer and the input copy are all 0, and every sense bit is 0.
- R9: `new_pend` is high for exactly the cycles in which at least one pending bit changed from 0 to 1. It shares the clock edge at which `pending` updates.
- R10: An input change reaches `pending` on the third rising clock edge after it: two synchronizer flops, then the pending register.
- R11: When a set condition and a clear condition for one line fall in the same cycle, the line ends up pending.
- R12: With `LEVEL_ONLY` = 1, every sense bit is 1 from reset onward and `sense_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw active-high request inputs, asynchronous |
| sense_we | input | 1 | Load the sense bits |
| sense_wdata | input | NUM_LINES | New sense bits (0 edge, 1 level) |
| clr_we | input | 1 | Clear-write strobe |
| clr_wdata | input | NUM_LINES | AND mask applied to pending |
| set_we | input | 1 | Set-write strobe |
| set_wdata | input | NUM_LINES | Set value; only its lowest set bit counts |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | LINE_W | Line number being acknowledged |
| pending | output | NUM_LINES | Pending vector |
| new_pend | output | 1 | One-cycle pulse when any line becomes pending |

## Verification
The bench builds two copies of the block. The first has 32 lines and switchable sense bits, so edge and level lines can sit next to each other. With it the bench can try acknowledge, clear-write and set-write against both modes, and it can place an acknowledge in the same cycle as a new edge. The second has 8 lines with `LEVEL_ONLY` set. With it the bench can show that the reset sense value is forced to level and that sense writes are ignored, using only the pending outputs.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;

  localparam int unsigned SYNC_DEPTH_DEFAULT = 2;

endpackage

// File: rtl/irqcap_sync.sv
module irqcap_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/irqcap_lowest.sv
module irqcap_lowest #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec,
  output logic [WIDTH-1:0] onehot
);

  // Bits below the current position that are already set.
  logic [WIDTH-1:0] seen_below;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (b == 0) begin : g_lsb
      assign seen_below[b] = 1'b0;
    end else begin : g_upper
      assign seen_below[b] = seen_below[b-1] | vec[b-1];
    end
    assign onehot[b] = vec[b] & ~seen_below[b];
  end

endmodule

// File: rtl/irqcap_cell.sv
module irqcap_cell
  import irqcap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode,
  input  logic   lvl,       // synchronized input level
  input  logic   prev,      // level one cycle earlier
  input  logic   clr_en,
  input  logic   clr_keep,  // mask bit of a clear-write
  input  logic   sw_set,
  input  logic   ack_hit,
  output logic   pend_o,
  output logic   rise_o
);

  logic is_level;
  logic edge_rise;
  logic lvl_fall;
  logic set_cond;
  logic clr_cond;
  logic pend_q;
  logic pend_d;

  assign is_level  = (mode == SENSE_LEVEL);
  assign edge_rise = ~is_level & lvl & ~prev;
  assign lvl_fall  = is_level & ~lvl & prev;

  assign set_cond = (is_level ? lvl : edge_rise) | sw_set;

  // Software clears are refused for a level line that is still driven.
  assign clr_cond = (clr_en & ~clr_keep & ~(is_level & lvl))
                  | (ack_hit & ~is_level)
                  | lvl_fall;

  // A set in the same cycle wins over any clear.
  assign pend_d = (pend_q & ~clr_cond) | set_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign rise_o = pend_d & ~pend_q;

endmodule

// File: rtl/irq_capture_latch.sv
module irq_capture_latch
  import irqcap_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter bit          LEVEL_ONLY  = 1'b0,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEFAULT,
  localparam int unsigned LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 sense_we,
  input  logic [NUM_LINES-1:0] sense_wdata,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_wdata,
  input  logic                 set_we,
  input  logic [NUM_LINES-1:0] set_wdata,
  input  logic                 ack_valid,
  input  logic [LINE_W-1:0]    ack_line,
  output logic [NUM_LINES-1:0] pending,
  output logic                 new_pend
);

  logic [NUM_LINES-1:0] in_sync;
  logic [NUM_LINES-1:0] in_prev;
  logic [NUM_LINES-1:0] sense_q;
  logic [NUM_LINES-1:0] set_pick;
  logic [NUM_LINES-1:0] rise_vec;

  irqcap_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_in),
    .q     (in_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_prev <= '0;
    else        in_prev <= in_sync;
  end

  if (LEVEL_ONLY) begin : g_sense_fixed
    assign sense_q = '1;
    logic unused_sense;
    assign unused_sense = sense_we ^ (^sense_wdata);
  end else begin : g_sense_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sense_q <= '0;
      else if (sense_we) sense_q <= sense_wdata;
    end
  end

  irqcap_lowest #(
    .WIDTH (NUM_LINES)
  ) lowest_i (
    .vec    (set_wdata),
    .onehot (set_pick)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irqcap_cell cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (sense_e'(sense_q[i])),
      .lvl      (in_sync[i]),
      .prev     (in_prev[i]),
      .clr_en   (clr_we),
      .clr_keep (clr_wdata[i]),
      .sw_set   (set_we & set_pick[i]),
      .ack_hit  (ack_valid && (ack_line == LINE_W'(i))),
      .pend_o   (pending[i]),
      .rise_o   (rise_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) new_pend <= 1'b0;
    else        new_pend <= |rise_vec;
  end

endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned LINE_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] sense_q,
  input logic [NUM_LINES-1:0] in_sync,
  input logic [NUM_LINES-1:0] in_prev,
  input logic                 clr_we,
  input logic [NUM_LINES-1:0] clr_wdata,
  input logic                 ack_valid,
  input logic [LINE_W-1:0]    ack_line,
  input logic [NUM_LINES-1:0] pending,
  input logic                 new_pend
);

  // R9: strobe only with a fresh pending bit
  p_strobe_has_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    new_pend |-> (|(pending & ~$past(pending))));

  // R9: every fresh pending bit comes with the strobe
  p_rise_has_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pending & ~$past(pending))) |-> new_pend);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    // R2: a new assertion on an edge line is captured
    p_edge_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!sense_q[i] && in_sync[i] && !in_prev[i]) |-> pending[i]);

    // R3: an active level line is pending
    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sense_q[i] && in_sync[i]) |-> pending[i]);

    // R4: an edge line loses its bit only through software
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending[i]) |->
        ($past(clr_we && !clr_wdata[i]) ||
         $past(ack_valid && ack_line == LINE_W'(i)) ||
         $past(sense_q[i])));
  end

endmodule

bind irq_capture_latch irq_capture_chk #(
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sense_q   (sense_q),
  .in_sync   (in_sync),
  .in_prev   (in_prev),
  .clr_we    (clr_we),
  .clr_wdata (clr_wdata),
  .ack_valid (ack_valid),
  .ack_line  (ack_line),
  .pending   (pending),
  .new_pend  (new_pend)
);

// File: tb/irq_capture_latch_tb_top.sv
module irq_capture_latch_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // 32-line build with switchable sense bits
  logic [31:0] irq_in = '0;
  logic        sense_we = 1'b0;
  logic [31:0] sense_wdata = '0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_wdata = '0;
  logic        set_we = 1'b0;
  logic [31:0] set_wdata = '0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_line = '0;
  logic [31:0] pending;
  logic        new_pend;

  // 8-line level-only build
  logic [7:0]  lo_irq = '0;
  logic        lo_sense_we = 1'b0;
  logic        lo_ack_valid = 1'b0;
  logic [2:0]  lo_ack_line = '0;
  logic [7:0]  lo_pending;
  logic        lo_new_pend;

  irq_capture_latch #(.NUM_LINES(32), .LEVEL_ONLY(1'b0)) dut_i (
    .clk, .rst_n, .irq_in, .sense_we, .sense_wdata, .clr_we, .clr_wdata,
    .set_we, .set_wdata, .ack_valid, .ack_line, .pending, .new_pend
  );

  irq_capture_latch #(.NUM_LINES(8), .LEVEL_ONLY(1'b1)) dut_lo_i (
    .clk (clk), .rst_n (rst_n), .irq_in (lo_irq),
    .sense_we (lo_sense_we), .sense_wdata (8'h00),
    .clr_we (1'b0), .clr_wdata (8'hFF),
    .set_we (1'b0), .set_wdata (8'h00),
    .ack_valid (lo_ack_valid), .ack_line (lo_ack_line),
    .pending (lo_pending), .new_pend (lo_new_pend)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_ack(input logic [4:0] line);
    ack_valid = 1'b1; ack_line = line;
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic do_clr(input logic [31:0] m);
    clr_we = 1'b1; clr_wdata = m;
    tick();
    clr_we = 1'b0;
  endtask

  task automatic do_set(input logic [31:0] v);
    set_we = 1'b1; set_wdata = v;
    tick();
    set_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 pending after reset", pending, 32'h0);
    check("R8 new_pend after reset", {31'h0, new_pend}, 32'h0);
    check("R8 level-only pending after reset", {24'h0, lo_pending}, 32'h0);
  endtask

  task automatic t_edge_capture;
    irq_in[3] = 1'b1;
    tick(2);
    check("R10 not yet pending after two edges", pending, 32'h0);
    tick();
    check("R2 edge line pending on rise", pending, 32'h8);
    check("R9 strobe with new pending", {31'h0, new_pend}, 32'h1);
    tick();
    check("R9 strobe lasts one cycle", {31'h0, new_pend}, 32'h0);
    irq_in[3] = 1'b0;
    tick(4);
    check("R4 edge line keeps bit after input drops", pending, 32'h8);
    do_ack(5'd3);
    check("R6 ack clears edge line", pending, 32'h0);
  endtask

  task automatic t_edge_held;
    irq_in[5] = 1'b1;
    tick(3);
    check("R2 edge line 5 captured", pending, 32'h20);
    do_ack(5'd5);
    tick(3);
    check("R2 held input does not set again", pending, 32'h0);
    irq_in[5] = 1'b0;
    tick(3);
  endtask

  task automatic t_ack_collision;
    do_set(32'h8);
    check("R7 set-write pends line 3", pending, 32'h8);
    irq_in[3] = 1'b1;
    tick(2);
    ack_valid = 1'b1; ack_line = 5'd3;
    tick();
    ack_valid = 1'b0;
    check("R11 rise beats same-cycle ack", pending, 32'h8);
    check("R9 no strobe for already pending line", {31'h0, new_pend}, 32'h0);
    irq_in[3] = 1'b0;
    tick(3);
    do_ack(5'd3);
    check("R6 cleanup ack", pending, 32'h0);
  endtask

  task automatic t_level;
    sense_we = 1'b1; sense_wdata = 32'h80;
    tick();
    sense_we = 1'b0;
    irq_in[7] = 1'b1;
    tick(3);
    check("R3 R1 level line pending", pending, 32'h80);
    do_ack(5'd7);
    check("R6 ack leaves level line", pending, 32'h80);
    do_clr(32'h0);
    check("R5 clear refused for active level line", pending, 32'h80);
    irq_in[7] = 1'b0;
    tick(2);
    check("R10 level fall not yet seen", pending, 32'h80);
    tick();
    check("R4 level line clears on fall", pending, 32'h0);
    sense_we = 1'b1; sense_wdata = 32'h0;
    tick();
    sense_we = 1'b0;
  endtask

  task automatic t_clear_mask;
    do_set(32'h8);
    do_set(32'h400);
    check("R7 two set-writes", pending, 32'h408);
    do_clr(~32'h8);
    check("R5 AND mask clears line 3 only", pending, 32'h400);
    do_clr(32'h0);
    check("R5 zero mask clears edge lines", pending, 32'h0);
  endtask

  task automatic t_set_lowest;
    do_set(32'h0000_0410);
    check("R7 only lowest set bit", pending, 32'h10);
    check("R9 strobe on set-write", {31'h0, new_pend}, 32'h1);
    do_set(32'h0);
    check("R7 zero set-write no change", pending, 32'h10);
    check("R9 no strobe on zero write", {31'h0, new_pend}, 32'h0);
    do_set(32'h10);
    check("R9 no strobe when already pending", {31'h0, new_pend}, 32'h0);
    do_clr(32'h0);
  endtask

  task automatic t_level_only;
    lo_sense_we = 1'b1;
    tick();
    lo_sense_we = 1'b0;
    lo_irq[2] = 1'b1;
    tick(3);
    check("R12 level-only line pending", {24'h0, lo_pending}, 32'h4);
    lo_ack_valid = 1'b1; lo_ack_line = 3'd2;
    tick();
    lo_ack_valid = 1'b0;
    check("R12 level-only ignores sense write, ack", {24'h0, lo_pending}, 32'h4);
    lo_irq[2] = 1'b0;
    tick(3);
    check("R12 level-only clears on fall", {24'h0, lo_pending}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_edge_capture();
    t_edge_held();
    t_ack_collision();
    t_level();
    t_clear_mask();
    t_set_lowest();
    t_level_only();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule